// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm and Interval Timer

This block keeps wall-clock calendar time (second, minute, hour, day, month, two-digit year and weekday) from a sub-clock enable. It counts a fixed number of enable pulses to form each one-second step. The default count of 32768 assumes a 32.768 kHz sub-clock. February lengthens to 29 days in leap years on its own. The weekday advances at every midnight.

Software sees an 8-bit register port. Time values are written into a staging set and then committed. The commit takes effect as one unit at the next second boundary, and the running count never stops. An alarm compares any chosen subset of year, month, day, hour and minute at each minute boundary and pulses one interrupt. An interval timer counts whole seconds and pulses its interrupt once, or repeatedly.

Top module: `cal_rtc`

## Requirements
- R1: One second step occurs on every PRESC_DIV-th clock cycle that has `sub_en` high. Each step advances the time by one second: seconds 0-59, minutes 0-59, hours 0-23, day from 1, month 1-12, year 0-99. Year 99 wraps to 0. The time never changes between steps. All values are plain binary.
- R2: Months 1, 3, 5, 7, 8, 10 and 12 have 31 days. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is divisible by 4 (00 included) and 28 days otherwise.
- R3: The weekday runs 0 to 6. It advances by one each time the day changes, and 6 wraps to 0.
- R4: A write to address 0 (second), 1 (minute), 2 (hour), 3 (day), 4 (month), 5 (year) or 6 (weekday) only fills a staging copy and leaves the running time unchanged. A write to address 7 with data bit 0 set arms a commit. At the next second step the whole staging copy replaces the time, no increment happens on that step, and the counting continues from there. Address 7 reads back 1 while a commit is armed.
- R5: `rd_data` is registered. It shows, one cycle after `rd_addr`, the live value at that address. Addresses 0-6 give the time fields, 8-12 the alarm values, 13 the alarm enable mask, 14/15 the interval's low and high bytes, and 16 the timer control. Unmapped addresses read 0.
- R6: Addresses 8-12 hold the alarm minute, hour, day, month and year. Address 13 bits 0-4 enable the compare of minute, hour, day, month and year respectively. When a counted step takes seconds from 59 to 00, `alarm_irq` pulses high for exactly one cycle on the next clock if the mask is nonzero and every enabled field equals the current time.
- R7: The alarm never fires when the mask is zero, when any enabled field differs, or when seconds reach 00 through a commit rather than through counting.
- R8: Addresses 14/15 hold a 16-bit interval in seconds, where 0 acts as 1. Writing address 16 sets enable (bit 0) and periodic (bit 1) and restarts the count from the interval. On each second step while enabled, the count goes down by one. When it reaches its last second, `timer_irq` pulses for one cycle in the same cycle as the time update. The count then reloads in periodic mode, or clears the enable bit in one-shot mode.
- R9: Synchronous active-high `rst` sets the time to 00:00:00, day 1, month 1, year 0, weekday 0. It clears the staging copy to the same values, clears the sub-second count, any armed commit, all alarm registers, the interval and the timer control, and drives both interrupts and `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_en | input | 1 | One-cycle pulse per sub-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Registered read data |
| alarm_irq | output | 1 | One-cycle alarm pulse |
| timer_irq | output | 1 | One-cycle interval timer pulse |

## Verification
A wrong carry in the calendar shows up at the read port within the one second step that crosses the faulty boundary. The same boundary also moves the alarm pulse, which depends on the whole date. A wrong sub-second count shifts every later second step, so the timer pulse and the time reads drift from the reference within one second. A commit applied at the wrong moment, or a lost commit, shows up at address 7 and at the time fields on the very next read. An alarm or timer pulse that is extra, missing or lasts too long differs from the reference in the cycle where it happens.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 8;
  localparam int ALARM_N = 5;   // minute, hour, day, month, year
  localparam int AFLD_W  = 7;
  localparam int IV_W    = 16;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] day;
    logic [2:0] dow;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  localparam cal_time_t TIME_RST = '{yr: 7'd0, mon: 4'd1, day: 5'd1, dow: 3'd0,
                                     hr: 5'd0, min: 6'd0, sec: 6'd0};

  localparam logic [ADDR_W-1:0] A_SEC    = 5'd0;
  localparam logic [ADDR_W-1:0] A_MIN    = 5'd1;
  localparam logic [ADDR_W-1:0] A_HR     = 5'd2;
  localparam logic [ADDR_W-1:0] A_DAY    = 5'd3;
  localparam logic [ADDR_W-1:0] A_MON    = 5'd4;
  localparam logic [ADDR_W-1:0] A_YR     = 5'd5;
  localparam logic [ADDR_W-1:0] A_DOW    = 5'd6;
  localparam logic [ADDR_W-1:0] A_COMMIT = 5'd7;
  localparam logic [ADDR_W-1:0] A_AL0    = 5'd8;
  localparam logic [ADDR_W-1:0] A_AMASK  = 5'd13;
  localparam logic [ADDR_W-1:0] A_IV_LO  = 5'd14;
  localparam logic [ADDR_W-1:0] A_IV_HI  = 5'd15;
  localparam logic [ADDR_W-1:0] A_TCTRL  = 5'd16;

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd2:                      month_len = (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   month_len = 5'd30;
      default:                   month_len = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_rtc_presc.sv
module cal_rtc_presc #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic sub_en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt;

  assign tick = sub_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (tick)    cnt <= '0;
    else if (sub_en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cal_rtc_calendar.sv
module cal_rtc_calendar
  import cal_rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      load_req,
  input  cal_time_t load_val,
  output cal_time_t cur,
  output logic      min_wrap
);
  cal_time_t  nxt;
  logic [4:0] mlen;

  always_comb begin
    nxt  = cur;
    mlen = month_len(cur.mon, cur.yr);
    if (cur.sec != 6'd59) nxt.sec = cur.sec + 6'd1;
    else begin
      nxt.sec = 6'd0;
      if (cur.min != 6'd59) nxt.min = cur.min + 6'd1;
      else begin
        nxt.min = 6'd0;
        if (cur.hr != 5'd23) nxt.hr = cur.hr + 5'd1;
        else begin
          nxt.hr  = 5'd0;
          nxt.dow = (cur.dow == 3'd6) ? 3'd0 : cur.dow + 3'd1;
          if (cur.day < mlen) nxt.day = cur.day + 5'd1;
          else begin
            nxt.day = 5'd1;
            if (cur.mon != 4'd12) nxt.mon = cur.mon + 4'd1;
            else begin
              nxt.mon = 4'd1;
              nxt.yr  = (cur.yr == 7'd99) ? 7'd0 : cur.yr + 7'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= TIME_RST;
      min_wrap <= 1'b0;
    end else begin
      min_wrap <= tick && !load_req && (cur.sec == 6'd59);
      if (tick) cur <= load_req ? load_val : nxt;
    end
  end
endmodule

// File: rtl/cal_rtc_alarm.sv
module cal_rtc_alarm
  import cal_rtc_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  cal_time_t                      cur,
  input  logic                           min_wrap,
  input  logic [ALARM_N-1:0][AFLD_W-1:0] al_val,
  input  logic [ALARM_N-1:0]             al_mask,
  output logic                           irq
);
  logic [ALARM_N-1:0][AFLD_W-1:0] now_f;
  logic [ALARM_N-1:0]             hit;

  assign now_f[0] = {1'b0, cur.min};
  assign now_f[1] = {2'b0, cur.hr};
  assign now_f[2] = {2'b0, cur.day};
  assign now_f[3] = {3'b0, cur.mon};
  assign now_f[4] = cur.yr;

  for (genvar i = 0; i < ALARM_N; i++) begin : g_cmp
    assign hit[i] = !al_mask[i] || (now_f[i] == al_val[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= min_wrap && (|al_mask) && (&hit);
  end
endmodule

// File: rtl/cal_rtc_timer.sv
module cal_rtc_timer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ld,
  input  logic          ld_en,
  input  logic          ld_per,
  input  logic [IW-1:0] interval,
  output logic          irq,
  output logic          en,
  output logic          per
);
  localparam logic [IW-1:0] ONE = IW'(1);

  logic [IW-1:0] cnt;
  logic [IW-1:0] ld_val;

  assign ld_val = (interval == '0) ? ONE : interval;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      en  <= 1'b0;
      per <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= tick && en && (cnt == ONE);
      if (tick && en) begin
        if (cnt == ONE) begin
          if (per) cnt <= ld_val;
          else     en  <= 1'b0;
        end else begin
          cnt <= cnt - ONE;
        end
      end
      if (ld) begin
        en  <= ld_en;
        per <= ld_per;
        cnt <= ld_val;
      end
    end
  end
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int PRESC_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sub_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              alarm_irq,
  output logic              timer_irq
);
  logic                           sec_tick;
  logic                           commit_pend;
  logic                           min_wrap;
  cal_time_t                      cur_time;
  cal_time_t                      staged;
  logic [ALARM_N-1:0][AFLD_W-1:0] al_val;
  logic [ALARM_N-1:0]             al_mask;
  logic [IV_W-1:0]                tmr_iv;
  logic                           tmr_en, tmr_per;
  logic [DATA_W-1:0]              rd_mux;

  cal_rtc_presc #(.DIV(PRESC_DIV)) presc_i (
    .clk(clk), .rst(rst), .sub_en(sub_en), .tick(sec_tick));

  cal_rtc_calendar cal_i (
    .clk(clk), .rst(rst), .tick(sec_tick), .load_req(commit_pend),
    .load_val(staged), .cur(cur_time), .min_wrap(min_wrap));

  cal_rtc_alarm alm_i (
    .clk(clk), .rst(rst), .cur(cur_time), .min_wrap(min_wrap),
    .al_val(al_val), .al_mask(al_mask), .irq(alarm_irq));

  cal_rtc_timer #(.IW(IV_W)) tmr_i (
    .clk(clk), .rst(rst), .tick(sec_tick),
    .ld(wr_en && (wr_addr == A_TCTRL)), .ld_en(wr_data[0]), .ld_per(wr_data[1]),
    .interval(tmr_iv), .irq(timer_irq), .en(tmr_en), .per(tmr_per));

  always_ff @(posedge clk) begin
    if (rst) begin
      staged      <= TIME_RST;
      commit_pend <= 1'b0;
      al_val      <= '0;
      al_mask     <= '0;
      tmr_iv      <= '0;
    end else begin
      if (sec_tick && commit_pend) commit_pend <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          A_SEC:    staged.sec <= wr_data[5:0];
          A_MIN:    staged.min <= wr_data[5:0];
          A_HR:     staged.hr  <= wr_data[4:0];
          A_DAY:    staged.day <= wr_data[4:0];
          A_MON:    staged.mon <= wr_data[3:0];
          A_YR:     staged.yr  <= wr_data[6:0];
          A_DOW:    staged.dow <= wr_data[2:0];
          A_COMMIT: if (wr_data[0]) commit_pend <= 1'b1;
          A_AMASK:  al_mask <= wr_data[ALARM_N-1:0];
          A_IV_LO:  tmr_iv[7:0]  <= wr_data;
          A_IV_HI:  tmr_iv[15:8] <= wr_data;
          default: begin
            for (int i = 0; i < ALARM_N; i++)
              if (wr_addr == A_AL0 + ADDR_W'(i)) al_val[i] <= wr_data[AFLD_W-1:0];
          end
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_SEC:    rd_mux = {2'b0, cur_time.sec};
      A_MIN:    rd_mux = {2'b0, cur_time.min};
      A_HR:     rd_mux = {3'b0, cur_time.hr};
      A_DAY:    rd_mux = {3'b0, cur_time.day};
      A_MON:    rd_mux = {4'b0, cur_time.mon};
      A_YR:     rd_mux = {1'b0, cur_time.yr};
      A_DOW:    rd_mux = {5'b0, cur_time.dow};
      A_COMMIT: rd_mux = {7'b0, commit_pend};
      A_AMASK:  rd_mux = {3'b0, al_mask};
      A_IV_LO:  rd_mux = tmr_iv[7:0];
      A_IV_HI:  rd_mux = tmr_iv[15:8];
      A_TCTRL:  rd_mux = {6'b0, tmr_per, tmr_en};
      default: begin
        for (int i = 0; i < ALARM_N; i++)
          if (rd_addr == A_AL0 + ADDR_W'(i)) rd_mux = {1'b0, al_val[i]};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
  import cal_rtc_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      sec_tick,
  input logic      pend,
  input cal_time_t cur,
  input logic      alarm_irq,
  input logic      timer_irq
);
  // R1: a counted step below 59 seconds adds exactly one second
  a_r1_sec_step: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !pend && cur.sec != 6'd59) |=> (cur.sec == 6'($past(cur.sec) + 6'd1)));

  // R1: time is frozen between second steps
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> $stable(cur));

  // R1: every field stays inside its legal range
  a_r1_ranges: assert property (@(posedge clk) disable iff (rst)
    (cur.sec < 6'd60) && (cur.min < 6'd60) && (cur.hr < 5'd24) && (cur.dow < 3'd7) &&
    (cur.mon >= 4'd1) && (cur.mon <= 4'd12) && (cur.yr < 7'd100) && (cur.day >= 5'd1));

  // R6: the alarm pulse lasts one cycle
  a_r6_alarm_single: assert property (@(posedge clk) disable iff (rst)
    alarm_irq |=> !alarm_irq);

  // R7: the alarm only appears at a whole minute
  a_r7_alarm_at_zero: assert property (@(posedge clk) disable iff (rst)
    alarm_irq |-> (cur.sec == 6'd0));

  // R8: the timer pulse lasts one cycle and follows a second step
  a_r8_timer_single: assert property (@(posedge clk) disable iff (rst)
    timer_irq |=> !timer_irq);

  a_r8_timer_after_tick: assert property (@(posedge clk) disable iff (rst)
    timer_irq |-> $past(sec_tick));
endmodule

bind cal_rtc cal_rtc_chk chk_i (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .pend(commit_pend), .cur(cur_time),
  .alarm_irq(alarm_irq), .timer_irq(timer_irq));

// File: tb/cal_rtc_tb_top.sv
`timescale 1ns/1ps
module cal_rtc_tb_top;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst, sub_en, we;
  logic [4:0] wa, ra;
  logic [7:0] wd;
  logic [7:0] rd_data;
  logic       alarm_irq, timer_irq;

  int checks = 0, errors = 0;
  int al_cnt = 0, tm_cnt = 0;

  // reference model state
  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_dow, m_presc;
  int sh[7];
  int al[5];
  int m_pend, m_rolled, amask, iv, ten, tper, tcnt;
  int e_rd, e_al, e_tm;

  always #4 clk = ~clk;

  cal_rtc #(.PRESC_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .sub_en(sub_en), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .rd_addr(ra), .rd_data(rd_data), .alarm_irq(alarm_irq), .timer_irq(timer_irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int rdval(input int a);
    case (a)
      0: return m_sec;   1: return m_min;  2: return m_hr;  3: return m_day;
      4: return m_mon;   5: return m_yr;   6: return m_dow; 7: return m_pend;
      8, 9, 10, 11, 12: return al[a-8];
      13: return amask;  14: return iv % 256; 15: return iv / 256;
      16: return tper * 2 + ten;
      default: return 0;
    endcase
  endfunction

  function automatic bit alarm_hit();
    int now[5];
    now = '{m_min, m_hr, m_day, m_mon, m_yr};
    for (int i = 0; i < 5; i++)
      if (amask[i] && now[i] != al[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model();
    bit tick;
    if (rst) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_dow = 0;
      sh = '{0, 0, 0, 1, 1, 0, 0};
      al = '{0, 0, 0, 0, 0};
      m_presc = 0; m_pend = 0; m_rolled = 0; amask = 0; iv = 0; ten = 0; tper = 0; tcnt = 0;
      e_rd = 0; e_al = 0; e_tm = 0;
      return;
    end
    tick = sub_en && (m_presc == DIV - 1);
    e_rd = rdval(int'(ra));
    e_al = (m_rolled && amask != 0 && alarm_hit()) ? 1 : 0;
    e_tm = (tick && ten != 0 && tcnt == 1) ? 1 : 0;
    if (tick && ten != 0) begin
      if (tcnt == 1) begin
        if (tper != 0) tcnt = (iv == 0) ? 1 : iv;
        else ten = 0;
      end else tcnt--;
    end
    m_rolled = (tick && m_pend == 0 && m_sec == 59) ? 1 : 0;
    if (tick) begin
      if (m_pend != 0) begin
        m_sec = sh[0]; m_min = sh[1]; m_hr = sh[2]; m_day = sh[3];
        m_mon = sh[4]; m_yr = sh[5]; m_dow = sh[6]; m_pend = 0;
      end else begin
        m_sec++;
        if (m_sec == 60) begin
          m_sec = 0; m_min++;
          if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin
              m_hr = 0; m_dow = (m_dow + 1) % 7; m_day++;
              if (m_day > mdays(m_mon, m_yr)) begin
                m_day = 1; m_mon++;
                if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
              end
            end
          end
        end
      end
    end
    m_presc = sub_en ? ((m_presc == DIV - 1) ? 0 : m_presc + 1) : m_presc;
    if (we) begin
      if (wa <= 6) sh[wa] = int'(wd);
      else if (wa == 7) begin if (wd[0]) m_pend = 1; end
      else if (wa >= 8 && wa <= 12) al[wa-8] = int'(wd);
      else if (wa == 13) amask = int'(wd) % 32;
      else if (wa == 14) iv = (iv / 256) * 256 + int'(wd);
      else if (wa == 15) iv = int'(wd) * 256 + iv % 256;
      else if (wa == 16) begin
        ten = int'(wd[0]); tper = int'(wd[1]); tcnt = (iv == 0) ? 1 : iv;
      end
    end
  endtask

  task automatic step();
    model();
    @(negedge clk);
    chk(rd_data == e_rd[7:0], "R5 rd_data", int'(rd_data), e_rd);
    chk(alarm_irq == e_al[0], "R6 alarm_irq", int'(alarm_irq), e_al);
    chk(timer_irq == e_tm[0], "R8 timer_irq", int'(timer_irq), e_tm);
    if (alarm_irq) al_cnt++;
    if (timer_irq) tm_cnt++;
  endtask

  task automatic wr(input int a, input int d);
    we = 1'b1; wa = 5'(a); wd = 8'(d);
    step();
    we = 1'b0;
  endtask

  task automatic secs(input int n);
    repeat (n * DIV) step();
  endtask

  task automatic expect_rd(input int a, input int v, input string tag);
    ra = 5'(a);
    step();
    chk(rd_data == 8'(v), tag, int'(rd_data), v);
  endtask

  task automatic jump(input int s, input int mi, input int h, input int d,
                      input int mo, input int y, input int w);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, d); wr(4, mo); wr(5, y); wr(6, w);
    wr(7, 1);
    while (m_pend != 0) step();
  endtask

  initial begin
    rst = 1'b1; sub_en = 1'b0; we = 1'b0; wa = '0; wd = '0; ra = '0;
    step(); step();
    expect_rd(3, 0, "R9 rd_data held at 0 in reset");
    rst = 1'b0;
    expect_rd(3, 1, "R9 day after reset");
    expect_rd(4, 1, "R9 month after reset");
    expect_rd(16, 0, "R9 timer control after reset");
    sub_en = 1'b1;
    ra = 5'd0;
    secs(3);
    expect_rd(0, 3, "R1 seconds after three steps");

    // R4: staged time applied at the next boundary
    wr(0, 58); wr(1, 59); wr(2, 23); wr(3, 28); wr(4, 2); wr(5, 24); wr(6, 6);
    expect_rd(1, 0, "R4 staging leaves live minute");
    wr(7, 1);
    expect_rd(7, 1, "R4 commit armed");
    while (m_pend != 0) step();
    expect_rd(0, 58, "R4 committed seconds");
    secs(2);
    expect_rd(3, 29, "R2 leap February day 29");
    expect_rd(4, 2, "R2 still February");
    expect_rd(6, 0, "R3 weekday 6 wraps to 0");

    jump(59, 59, 23, 28, 2, 23, 2);
    secs(1);
    expect_rd(3, 1, "R2 non-leap February ends at 28");
    expect_rd(4, 3, "R2 March follows");

    jump(59, 59, 23, 31, 12, 99, 5);
    secs(1);
    expect_rd(5, 0, "R1 year 99 wraps to 0");
    expect_rd(4, 1, "R1 month wraps to 1");
    expect_rd(6, 6, "R3 weekday advances");

    jump(59, 59, 23, 30, 4, 10, 1);
    secs(1);
    expect_rd(4, 5, "R2 April has 30 days");
    expect_rd(3, 1, "R2 day 1 of May");

    // R6 / R7: alarm
    wr(8, 5); wr(13, 1);
    jump(58, 4, 10, 15, 6, 30, 0); al_cnt = 0; secs(4);
    chk(al_cnt == 1, "R6 minute-only alarm pulse count", al_cnt, 1);
    wr(9, 10); wr(10, 15); wr(11, 6); wr(12, 30); wr(13, 31);
    jump(58, 4, 10, 15, 6, 30, 0); al_cnt = 0; secs(4);
    chk(al_cnt == 1, "R6 all-field alarm pulse count", al_cnt, 1);
    wr(10, 16);
    jump(58, 4, 10, 15, 6, 30, 0); al_cnt = 0; secs(4);
    chk(al_cnt == 0, "R7 mismatched day gives no alarm", al_cnt, 0);
    wr(13, 0);
    jump(58, 4, 10, 15, 6, 30, 0); al_cnt = 0; secs(4);
    chk(al_cnt == 0, "R7 zero mask gives no alarm", al_cnt, 0);
    wr(13, 1);
    jump(0, 5, 10, 15, 6, 30, 0); al_cnt = 0; secs(3);
    chk(al_cnt == 0, "R7 commit to :00 gives no alarm", al_cnt, 0);
    wr(13, 2);
    jump(59, 59, 9, 15, 6, 30, 0); al_cnt = 0; secs(3);
    chk(al_cnt == 1, "R6 hour-only alarm pulse count", al_cnt, 1);
    wr(13, 0);

    // R8: timer
    wr(14, 3); wr(15, 0);
    tm_cnt = 0; wr(16, 1); secs(6);
    chk(tm_cnt == 1, "R8 one-shot pulse count", tm_cnt, 1);
    expect_rd(16, 0, "R8 one-shot clears enable");
    wr(14, 2);
    wr(16, 3); tm_cnt = 0; repeat (80) step();
    chk(tm_cnt == 10, "R8 periodic pulse count", tm_cnt, 10);
    wr(16, 0); tm_cnt = 0; secs(3);
    chk(tm_cnt == 0, "R8 disabled timer is silent", tm_cnt, 0);
    wr(14, 0);
    wr(16, 3); tm_cnt = 0; repeat (40) step();
    chk(tm_cnt == 10, "R8 interval 0 acts as 1", tm_cnt, 10);
    wr(16, 0);
    wr(15, 1);
    expect_rd(15, 1, "R5 interval high byte");

    // R1: gated sub-clock enable
    for (int i = 0; i < 90; i++) begin
      sub_en = (i % 3 != 0);
      step();
    end
    sub_en = 1'b1;

    // R9: reset mid-run
    rst = 1'b1; step(); rst = 1'b0;
    expect_rd(13, 0, "R9 alarm mask cleared");
    expect_rd(15, 0, "R9 interval cleared");
    expect_rd(2, 0, "R9 hour cleared");
    secs(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule